// File: doc/BRIEF.md
# Floppy Read Preamble Synchronizer

This block sits behind a floppy data separator and watches the stream of half-bit-cell samples that arrives one per strobe. While hunting, it groups the samples into consecutive pairs. A pair whose two halves differ extends a run counter, and a pair with equal halves clears it. Once the run is long enough, the block declares the track synchronized. It then fixes the bit-cell phase from the recording mode and the last half-bit it saw.

Two recording modes are supported. The native mode runs at twice the bit rate of the IBM-compatible mode. Its sync field consists of 1 data bits, which gives a clock/data pattern of 0,1. The IBM-compatible sync field consists of 0 data bits, which gives 1,0. At synchronization the block presets an 8-bit clock shift register and an 8-bit data shift register to the values that follow such a field. When framing is off by half a cell, it raises a one-cycle slip request and drops one half-bit. From then on it steers accepted half-bits alternately into the two registers.

A loopback setting skips both the alignment and the preset, because byte framing is already known in that case. The block also paces the data separator by issuing a half-bit request at the rate of the selected mode.

Top module: `fdd_preamble_sync`

## Requirements
- R1: While searching, a pair whose second half-bit equals its first clears `sync_count` to 0. The count is visible from the cycle after the second strobe.
- R2: A pair whose halves differ increments `sync_count`. On the pair that brings it to SYNC_RUN (default 29), `synced` goes to 1 and `lockup` goes to 0 in the cycle after that strobe. Until then, `synced` stays at 0.
- R3: `sync_count` never exceeds SYNC_RUN. After synchronization it holds at SYNC_RUN while data is shifted.
- R4: At synchronization without loopback, `slip` pulses high for exactly one cycle if and only if the last half-bit differs from `native_mode` (1 = native, 0 = IBM-compatible). The next accepted strobe after that is discarded and changes neither register.
- R5: At synchronization in native mode without loopback, `clk_sr` becomes all zeros and `dat_sr` becomes all ones.
- R6: At synchronization in IBM-compatible mode without loopback, `clk_sr` becomes all ones and `dat_sr` becomes all zeros.
- R7: With `loopback` = 1 at synchronization, there is no slip pulse and no preset. Both registers keep their cleared value of zero.
- R8: After synchronization, accepted half-bits alternate between the registers, with the clock register first. Each register shifts left, so the new half-bit enters bit 0 and the oldest half-bit leaves from the MSB.
- R9: With `read_en` = 0 or `rst` = 1, on the next edge `lockup` = 1, `synced` = 0, `slip` = 0, `sync_count` = 0, both registers are 0, and the pair phase restarts. This takes precedence over a strobe in the same cycle.
- R10: While `read_en` = 1, `hb_req` pulses once every HALF_NATIVE clocks in native mode and once every 2·HALF_NATIVE clocks in IBM-compatible mode. It stays at 0 while `read_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| read_en | input | 1 | Read path enable; low holds the block in search |
| native_mode | input | 1 | 1 = native mode, 0 = IBM-compatible mode |
| loopback | input | 1 | Skip alignment and preset at synchronization |
| hb_valid | input | 1 | Half-bit strobe from the data separator |
| hb_bit | input | 1 | Half-bit sample value |
| hb_req | output | 1 | Half-bit pacing pulse at the mode rate |
| lockup | output | 1 | 1 while searching for the sync field |
| synced | output | 1 | 1 once synchronization has been declared |
| slip | output | 1 | One-cycle request to drop a half-bit |
| sync_count | output | $clog2(SYNC_RUN+1) | Current run of alternating pairs |
| clk_sr | output | SR_W | Clock half-bit shift register |
| dat_sr | output | SR_W | Data half-bit shift register |

## Verification
The delicate overlap is a half-bit strobe arriving in the same cycle that `slip` is high. That strobe must be swallowed rather than shifted. The bench provokes this by issuing a strobe immediately after the synchronizing pair, for every combination of mode, loopback and starting phase. It then judges the result by checking that the registers still hold their preset and that the following strobe lands in the clock register. A second overlap is `read_en` dropping in the same cycle as the pair that would complete synchronization. For this case the bench expects a cleared count and no `synced` flag.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic {
        REC_IBM    = 1'b0,
        REC_NATIVE = 1'b1
    } rec_mode_e;

    // Clock register preset after a sync field: native fields carry clock 0s
    function automatic logic clock_fill(input rec_mode_e m);
        return (m == REC_NATIVE) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/fps_rate_gen.sv
module fps_rate_gen #(
    parameter int HALF_NATIVE = 250,
    localparam int CW = $clog2(2 * HALF_NATIVE)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic native,
    output logic req
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          req;
    } rate_t;

    rate_t st_q, st_d;
    logic [CW-1:0] limit;

    always_comb begin
        limit = native ? CW'(HALF_NATIVE - 1) : CW'(2 * HALF_NATIVE - 1);
        st_d = st_q;
        st_d.req = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (st_q.cnt >= limit) begin
            st_d.cnt = '0;
            st_d.req = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req = st_q.req;

    assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    assert_req_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> !req);

endmodule

// File: rtl/fps_pair_sync.sv
module fps_pair_sync #(
    parameter int SYNC_RUN = 29,
    localparam int CNT_W = $clog2(SYNC_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hb_valid,
    input  logic             hb_bit,
    output logic             synced,
    output logic             hit,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic             phase;
        logic             first;
        logic [CNT_W-1:0] cnt;
        logic             synced;
    } pair_t;

    pair_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (!st_q.synced && hb_valid) begin
            if (!st_q.phase) begin
                st_d.phase = 1'b1;
                st_d.first = hb_bit;
            end else begin
                st_d.phase = 1'b0;
                if (hb_bit == st_q.first) begin
                    st_d.cnt = '0;
                end else begin
                    if (st_q.cnt != CNT_W'(SYNC_RUN))
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    if (st_q.cnt == CNT_W'(SYNC_RUN - 1)) begin
                        st_d.synced = 1'b1;
                        hit = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign synced = st_q.synced;
    assign count  = st_q.cnt;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(SYNC_RUN));
    assert_sync_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> $past(hb_valid) && $past(run));
    assert_equal_pair_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (run && hb_valid && st_q.phase && !st_q.synced && hb_bit == st_q.first) |=> count == '0);

endmodule

// File: rtl/fps_framer.sv
module fps_framer
    import fps_pkg::*;
#(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            synced,
    input  logic            hit,
    input  logic            native,
    input  logic            loopback,
    input  logic            hb_valid,
    input  logic            hb_bit,
    output logic            slip,
    output logic [SR_W-1:0] clk_sr,
    output logic [SR_W-1:0] dat_sr
);
    typedef struct packed {
        logic            sel;
        logic            skip;
        logic            slip;
        logic [SR_W-1:0] c;
        logic [SR_W-1:0] d;
    } frm_t;

    frm_t st_q, st_d;
    rec_mode_e mode;

    always_comb begin
        mode = rec_mode_e'(native);
        st_d = st_q;
        st_d.slip = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (hit) begin
            st_d.sel = 1'b0;
            if (!loopback) begin
                st_d.c = {SR_W{clock_fill(mode)}};
                st_d.d = {SR_W{~clock_fill(mode)}};
                if (hb_bit != native) begin
                    st_d.skip = 1'b1;
                    st_d.slip = 1'b1;
                end
            end
        end else if (synced && hb_valid) begin
            if (st_q.skip) begin
                st_d.skip = 1'b0;
            end else if (!st_q.sel) begin
                st_d.c   = {st_q.c[SR_W-2:0], hb_bit};
                st_d.sel = 1'b1;
            end else begin
                st_d.d   = {st_q.d[SR_W-2:0], hb_bit};
                st_d.sel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slip   = st_q.slip;
    assign clk_sr = st_q.c;
    assign dat_sr = st_q.d;

    assert_slip_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        slip |=> !slip);
    assert_skip_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (run && synced && hb_valid && st_q.skip) |=> $stable(clk_sr) && $stable(dat_sr));
    assert_clock_first_R8: assert property (@(posedge clk) disable iff (rst)
        (run && synced && hb_valid && !st_q.skip && !st_q.sel) |=> $stable(dat_sr));

endmodule

// File: rtl/fdd_preamble_sync.sv
module fdd_preamble_sync #(
    parameter int SYNC_RUN    = 29,
    parameter int SR_W        = 8,
    parameter int HALF_NATIVE = 250,
    localparam int CNT_W = $clog2(SYNC_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             read_en,
    input  logic             native_mode,
    input  logic             loopback,
    input  logic             hb_valid,
    input  logic             hb_bit,
    output logic             hb_req,
    output logic             lockup,
    output logic             synced,
    output logic             slip,
    output logic [CNT_W-1:0] sync_count,
    output logic [SR_W-1:0]  clk_sr,
    output logic [SR_W-1:0]  dat_sr
);
    logic sync_hit;

    fps_rate_gen #(.HALF_NATIVE(HALF_NATIVE)) u_rate (
        .clk(clk), .rst(rst), .run(read_en), .native(native_mode), .req(hb_req)
    );

    fps_pair_sync #(.SYNC_RUN(SYNC_RUN)) u_pair (
        .clk(clk), .rst(rst), .run(read_en), .hb_valid(hb_valid), .hb_bit(hb_bit),
        .synced(synced), .hit(sync_hit), .count(sync_count)
    );

    fps_framer #(.SR_W(SR_W)) u_frm (
        .clk(clk), .rst(rst), .run(read_en), .synced(synced), .hit(sync_hit),
        .native(native_mode), .loopback(loopback), .hb_valid(hb_valid), .hb_bit(hb_bit),
        .slip(slip), .clk_sr(clk_sr), .dat_sr(dat_sr)
    );

    assign lockup = !synced;

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !read_en |=> !synced && !slip && sync_count == '0 && clk_sr == '0 && dat_sr == '0);
    assert_native_preset_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(synced) && $past(native_mode) && !$past(loopback)) |-> clk_sr == '0 && dat_sr == '1);
    assert_ibm_preset_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(synced) && !$past(native_mode) && !$past(loopback)) |-> clk_sr == '1 && dat_sr == '0);
    assert_loopback_plain_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(synced) && $past(loopback)) |-> !slip && clk_sr == '0 && dat_sr == '0);

endmodule

// File: tb/sim_fdd_preamble_sync.sv
`timescale 1ns/1ps
module sim_fdd_preamble_sync;
    localparam int RUN = 29;
    localparam int HN  = 6;

    logic clk = 1'b0;
    logic rst, read_en, native_mode, loopback, hb_valid, hb_bit;
    logic hb_req, lockup, synced, slip;
    logic [4:0] sync_count;
    logic [7:0] clk_sr, dat_sr;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fdd_preamble_sync #(.SYNC_RUN(RUN), .SR_W(8), .HALF_NATIVE(HN)) u0 (
        .clk(clk), .rst(rst), .read_en(read_en), .native_mode(native_mode),
        .loopback(loopback), .hb_valid(hb_valid), .hb_bit(hb_bit), .hb_req(hb_req),
        .lockup(lockup), .synced(synced), .slip(slip), .sync_count(sync_count),
        .clk_sr(clk_sr), .dat_sr(dat_sr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic b);
        hb_valid = 1'b1; hb_bit = b;
        @(negedge clk);
        hb_valid = 1'b0;
    endtask

    task automatic restart;
        strobe(1'b1);
        read_en = 1'b0;
        @(negedge clk);
        chk("R9 count", 32'(sync_count), 0);
        chk("R9 flags", {lockup, synced, slip}, 3'b100);
        chk("R9 regs", {clk_sr, dat_sr}, 0);
        read_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; read_en = 0; native_mode = 1; loopback = 0; hb_valid = 0; hb_bit = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 reset state", {lockup, synced, slip, hb_req}, 4'b1000);
        chk("R9 reset regs", {3'b0, sync_count, clk_sr, dat_sr}, 0);
        read_en = 1;

        // R1: equal pairs clear the run
        for (int k = 0; k < 7; k++) begin
            restart();
            for (int p = 0; p < k; p++) begin strobe(1'b0); strobe(1'b1); end
            chk("R1 run length", 32'(sync_count), 32'(k));
            strobe(k[0]); strobe(k[0]);
            chk("R1 equal pair clears", 32'(sync_count), 0);
        end

        // R2..R8 sweep over mode, loopback, phase
        for (int m = 0; m < 2; m++)
        for (int lb = 0; lb < 2; lb++)
        for (int ph = 0; ph < 2; ph++) begin
            logic [7:0] pc, pd, cb, db;
            logic exp_slip;
            restart();
            native_mode = m[0]; loopback = lb[0];
            for (int p = 0; p < RUN - 1; p++) begin strobe(ph[0]); strobe(!ph[0]); end
            chk("R2 not yet synced", {synced, lockup}, 2'b01);
            chk("R2 count before", 32'(sync_count), RUN - 1);
            strobe(ph[0]); strobe(!ph[0]);
            chk("R2 synced", {synced, lockup}, 2'b10);
            exp_slip = !lb[0] && ((!ph[0]) != m[0]);
            chk("R4 slip pulse", 32'(slip), 32'(exp_slip));
            pc = lb[0] ? 8'h00 : (m[0] ? 8'h00 : 8'hFF);
            pd = lb[0] ? 8'h00 : (m[0] ? 8'hFF : 8'h00);
            if (lb[0])      chk("R7 no preset", {clk_sr, dat_sr}, {pc, pd});
            else if (m[0])  chk("R5 native preset", {clk_sr, dat_sr}, {pc, pd});
            else            chk("R6 ibm preset", {clk_sr, dat_sr}, {pc, pd});
            if (exp_slip) begin
                strobe(1'b1);  // arrives while slip is high
                chk("R4 slip ends", 32'(slip), 0);
                chk("R4 dropped half-bit", {clk_sr, dat_sr}, {pc, pd});
            end
            cb = 8'hA5 ^ 8'(m * 3 + lb * 5 + ph * 9);
            db = 8'h3C ^ 8'(m * 7 + lb * 2 + ph * 4);
            strobe(cb[7]);
            chk("R8 clock first", {clk_sr, dat_sr}, {pc[6:0], cb[7], pd});
            strobe(db[7]);
            chk("R8 data second", 32'(dat_sr), {24'b0, pd[6:0], db[7]});
            for (int i = 6; i >= 0; i--) begin strobe(cb[i]); strobe(db[i]); end
            chk("R8 bytes", {clk_sr, dat_sr}, {cb, db});
            chk("R3 count holds", 32'(sync_count), RUN);
        end

        // R9: disable in the same cycle as the completing strobe
        restart();
        native_mode = 1; loopback = 0;
        for (int p = 0; p < RUN - 1; p++) begin strobe(1'b0); strobe(1'b1); end
        strobe(1'b0);
        read_en = 0; hb_valid = 1; hb_bit = 1;
        @(negedge clk);
        hb_valid = 0;
        chk("R9 disable wins", {synced, lockup, 3'b0, sync_count}, {2'b01, 8'd0});
        read_en = 1;

        // R10: request spacing
        for (int m = 1; m >= 0; m--) begin
            int gap;
            native_mode = m[0];
            read_en = 0; @(negedge clk); read_en = 1;
            gap = 0;
            while (!hb_req && gap < 100) begin @(negedge clk); gap++; end
            gap = 0;
            @(negedge clk); gap++;
            while (!hb_req && gap < 100) begin @(negedge clk); gap++; end
            chk("R10 spacing", 32'(gap), m[0] ? HN : 2 * HN);
        end
        read_en = 0;
        begin
            int seen = 0;
            @(negedge clk);
            repeat (30) begin @(negedge clk); if (hb_req) seen++; end
            chk("R10 idle", 32'(seen), 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule